// File: doc/BRIEF.md
# Packed Unsigned Shift-Right-Accumulate Unit

This block is a packed-integer datapath stage. It takes a source vector and an accumulator vector, splits both into unsigned lanes, and shifts every source lane right by a constant. Each shifted value is added to the matching accumulator lane and the packed sum is returned. A 7-bit immediate, given as a 4-bit upper field and a 3-bit lower field, selects both the lane width and the shift count. The highest set bit of the upper field fixes the lane width. The shift is twice that width minus the whole immediate read as an unsigned number.

A width-select input chooses a 64-bit or a 128-bit datapath. A mode input chooses vector operation or a scalar form. The scalar form always works on a single 64-bit element. Encodings that are reserved raise an undefined flag. Encodings that belong to a different operation class raise a separate flag. In both cases the result is forced to zero. Every operation takes exactly one clock cycle from the valid input to the registered result, whatever the operand values.

Top module: `usra_unit`

## Requirements
- R1: In vector mode the lane width follows the highest set bit of `imm_hi`: bit 0 only gives 8, bit 1 highest gives 16, bit 2 highest gives 32, and bit 3 set gives 64.
- R2: The right-shift count is twice the lane width minus the unsigned value of `{imm_hi, imm_lo}`, which yields a count from 1 up to the lane width.
- R3: `wide_sel`=0 selects a 64-bit datapath and `wide_sel`=1 selects a 128-bit datapath, split into datapath-width / lane-width lanes. With the 64-bit datapath (and in scalar mode), `result[127:64]` is zero.
- R4: In vector mode, `imm_hi`=4'b0000 raises `other_class_flag`, keeps `undef_flag` low and gives a zero result.
- R5: In vector mode, `imm_hi[3]`=1 together with `wide_sel`=0 raises `undef_flag` and gives a zero result.
- R6: In scalar mode the unit works on one 64-bit element with shift 128 - `{imm_hi, imm_lo}` (1 to 64). `wide_sel` is ignored. If `imm_hi[3]`=0, `undef_flag` is raised and the result is zero.
- R7: Lanes are unsigned. The shift fills with zeros and drops the shifted-out bits without any rounding.
- R8: Each lane result is the accumulator lane plus the shifted source lane, truncated to the lane width (the sum wraps modulo 2^width).
- R9: A shift equal to the lane width gives a shifted value of zero, so the result lane equals the accumulator lane.
- R10: `out_valid` rises exactly one cycle after `in_valid`, with the matching result and flags. While `in_valid` is low, `result` and the flags hold their values and `out_valid` is low.
- R11: While reset is applied, `out_valid`, `result`, `undef_flag` and `other_class_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operation request, one cycle per operation |
| src_vec | input | 128 | Source vector whose lanes are shifted |
| acc_vec | input | 128 | Accumulator vector |
| imm_hi | input | 4 | Upper immediate field (lane width selector) |
| imm_lo | input | 3 | Lower immediate field |
| wide_sel | input | 1 | 0: 64-bit datapath, 1: 128-bit datapath |
| scalar_mode | input | 1 | 1: single 64-bit scalar element |
| out_valid | output | 1 | Registered result valid |
| result | output | 128 | Packed accumulated result |
| undef_flag | output | 1 | Reserved or undefined encoding |
| other_class_flag | output | 1 | Encoding belongs to a different operation class |

## Verification
The bench builds the unit with its default 128-bit vector width. Because the encoding fixes the lane widths, this is the only width that reaches every lane size on both datapath widths. With it, the full space of 128 immediates × two datapath widths × two modes can be swept against several operand patterns. The sweep therefore covers every decode path, every shift count including the full-lane shift, and both flag classes. Directed vectors add saturated operands that force lane wrap-around and truncation, and an idle cycle that shows the result register holding its value.

// File: rtl/usra_pkg.sv
package usra_pkg;
  localparam int IMM_HI_W = 4;
  localparam int IMM_LO_W = 3;
  localparam int IMM_W    = IMM_HI_W + IMM_LO_W;
  localparam int SHAMT_W  = 7;
  localparam int MIN_LANE = 8;
  localparam int N_SIZES  = 4;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } lane_sz_e;

  typedef struct packed {
    lane_sz_e             size;
    logic [SHAMT_W-1:0]   shamt;
    logic                 wide;
    logic                 undef;
    logic                 other;
  } dec_t;
endpackage

// File: rtl/usra_decode.sv
module usra_decode
  import usra_pkg::*;
(
  input  logic [IMM_HI_W-1:0] imm_hi,
  input  logic [IMM_LO_W-1:0] imm_lo,
  input  logic                wide_sel,
  input  logic                scalar_mode,
  output dec_t                dec
);
  logic [IMM_W:0]  imm_ext;
  logic [IMM_W:0]  twice_w;
  logic [IMM_W:0]  diff;
  lane_sz_e        size_v;

  assign imm_ext = {1'b0, imm_hi, imm_lo};

  always_comb begin
    if (imm_hi[3])      size_v = SZ_64;
    else if (imm_hi[2]) size_v = SZ_32;
    else if (imm_hi[1]) size_v = SZ_16;
    else                size_v = SZ_8;
  end

  always_comb begin
    dec = '0;
    if (scalar_mode) begin
      dec.size  = SZ_64;
      dec.wide  = 1'b0;
      dec.undef = ~imm_hi[3];
      dec.other = 1'b0;
    end else begin
      dec.size  = size_v;
      dec.wide  = wide_sel;
      dec.other = (imm_hi == '0);
      dec.undef = imm_hi[3] & ~wide_sel;
    end
    twice_w   = (IMM_W+1)'(2 * MIN_LANE) << dec.size;
    diff      = twice_w - imm_ext;
    dec.shamt = diff[SHAMT_W-1:0];
  end
endmodule

// File: rtl/usra_lane.sv
module usra_lane
  import usra_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0]      src,
  input  logic [LW-1:0]      acc,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [LW-1:0]      sum
);
  logic [LW-1:0] shifted;

  always_comb begin
    if (int'(shamt) >= LW) shifted = '0;
    else                   shifted = src >> shamt;
    sum = acc + shifted;
  end
endmodule

// File: rtl/usra_datapath.sv
module usra_datapath
  import usra_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W-1:0]   acc_vec,
  input  dec_t               dec,
  output logic [VEC_W-1:0]   res
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] res_sz [N_SIZES];
  logic [VEC_W-1:0] sel;

  for (genvar s = 0; s < N_SIZES; s++) begin : g_sz
    localparam int LW = MIN_LANE << s;
    localparam int NL = VEC_W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      usra_lane #(.LW(LW)) u_lane (
        .src   (src_vec[l*LW +: LW]),
        .acc   (acc_vec[l*LW +: LW]),
        .shamt (dec.shamt),
        .sum   (res_sz[s][l*LW +: LW])
      );
    end
  end

  always_comb begin
    sel = res_sz[dec.size];
    res = sel;
    if (!dec.wide) res[VEC_W-1:HALF_W] = '0;
  end
endmodule

// File: rtl/usra_unit.sv
module usra_unit
  import usra_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [VEC_W-1:0]    src_vec,
  input  logic [VEC_W-1:0]    acc_vec,
  input  logic [IMM_HI_W-1:0] imm_hi,
  input  logic [IMM_LO_W-1:0] imm_lo,
  input  logic                wide_sel,
  input  logic                scalar_mode,
  output logic                out_valid,
  output logic [VEC_W-1:0]    result,
  output logic                undef_flag,
  output logic                other_class_flag
);
  localparam int HALF_W = VEC_W / 2;

  logic             rst_s1, rst_s2;
  dec_t             dec;
  logic [VEC_W-1:0] dp_res;
  logic [VEC_W-1:0] result_d;
  logic             undef_d, other_d, valid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  usra_decode u_dec (
    .imm_hi      (imm_hi),
    .imm_lo      (imm_lo),
    .wide_sel    (wide_sel),
    .scalar_mode (scalar_mode),
    .dec         (dec)
  );

  usra_datapath #(.VEC_W(VEC_W)) u_dp (
    .src_vec (src_vec),
    .acc_vec (acc_vec),
    .dec     (dec),
    .res     (dp_res)
  );

  always_comb begin
    valid_d  = in_valid;
    undef_d  = undef_flag;
    other_d  = other_class_flag;
    result_d = result;
    if (in_valid) begin
      undef_d  = dec.undef;
      other_d  = dec.other;
      result_d = (dec.undef || dec.other) ? '0 : dp_res;
    end
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      out_valid        <= 1'b0;
      result           <= '0;
      undef_flag       <= 1'b0;
      other_class_flag <= 1'b0;
    end else begin
      out_valid        <= valid_d;
      result           <= result_d;
      undef_flag       <= undef_d;
      other_class_flag <= other_d;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_s2)
    in_valid |=> out_valid); // R10
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_s2)
    !in_valid |=> !out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_s2)
    !in_valid |=> $stable(result)); // R10
  AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_s2)
    (undef_flag || other_class_flag) |-> (result == '0)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_s2)
    !(undef_flag && other_class_flag)); // R4
  AST_OTHER_CLASS: assert property (@(posedge clk) disable iff (!rst_s2)
    (in_valid && !scalar_mode && imm_hi == '0) |=> other_class_flag); // R4
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_s2)
    (in_valid && (!wide_sel || scalar_mode)) |=> (result[VEC_W-1:HALF_W] == '0)); // R3
  AST_SHAMT_RANGE: assert property (@(posedge clk) disable iff (!rst_s2)
    (in_valid && !dec.undef && !dec.other) |->
      (dec.shamt != '0 && int'(dec.shamt) <= (MIN_LANE << dec.size))); // R2
endmodule

// File: tb/sim_usra_unit.sv
module sim_usra_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic [127:0] acc_vec = '0;
  logic [3:0]   imm_hi = '0;
  logic [2:0]   imm_lo = '0;
  logic         wide_sel = 1'b0;
  logic         scalar_mode = 1'b0;
  logic         out_valid;
  logic [127:0] result;
  logic         undef_flag, other_class_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  usra_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_vec(src_vec), .acc_vec(acc_vec),
    .imm_hi(imm_hi), .imm_lo(imm_lo),
    .wide_sel(wide_sel), .scalar_mode(scalar_mode),
    .out_valid(out_valid), .result(result),
    .undef_flag(undef_flag), .other_class_flag(other_class_flag)
  );

  function automatic void model(input logic [127:0] s, input logic [127:0] a,
                                input logic [3:0] h, input logic [2:0] l,
                                input bit q, input bit sc,
                                output logic [127:0] r, output bit u, output bit o,
                                output int sh, output int w);
    int imm;
    int nl;
    logic [127:0] m, sv, av, shv, sm;
    imm = int'({h, l});
    if (sc) begin
      u = !h[3]; o = 0; w = 64; sh = 128 - imm; nl = 1;
    end else begin
      o = (h == 4'd0);
      u = !o && h[3] && !q;
      w = h[3] ? 64 : h[2] ? 32 : h[1] ? 16 : 8;
      sh = 2*w - imm;
      nl = (q ? 128 : 64) / w;
    end
    r = '0;
    if (!u && !o) begin
      m = (w == 64) ? {64'd0, {64{1'b1}}} : ((128'd1 << w) - 128'd1);
      for (int e = 0; e < nl; e++) begin
        sv  = (s >> (e*w)) & m;
        av  = (a >> (e*w)) & m;
        shv = (sh >= w) ? '0 : (sv >> sh);
        sm  = (av + shv) & m;
        r   = r | (sm << (e*w));
      end
    end
  endfunction

  task automatic check(input string tag, input bit ok,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [127:0] s, input logic [127:0] a,
                         input logic [3:0] h, input logic [2:0] l,
                         input bit q, input bit sc, input string force_tag);
    logic [127:0] er;
    bit eu, eo;
    int sh, w;
    string tag;
    model(s, a, h, l, q, sc, er, eu, eo, sh, w);
    if (force_tag != "")   tag = force_tag;
    else if (eo)           tag = "R4";
    else if (eu && !sc)    tag = "R5";
    else if (sc)           tag = "R6";
    else if (sh == w)      tag = "R9";
    else                   tag = "R1/R2/R3";
    src_vec = s; acc_vec = a; imm_hi = h; imm_lo = l;
    wide_sel = q; scalar_mode = sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_valid === 1'b1 && result === er &&
               undef_flag === eu && other_class_flag === eo,
          {out_valid, undef_flag, other_class_flag, result[124:0]},
          {1'b1, eu, eo, er[124:0]});
    if (result !== er)
      $display("  detail %s imm=%0d q=%0d sc=%0d res=%h exp=%h",
               tag, int'({h, l}), q, sc, result, er);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [127:0] pat_s [6];
    logic [127:0] pat_a [6];
    logic [127:0] hold_v;
    pat_s[0] = {128{1'b1}};                      pat_a[0] = '0;
    pat_s[1] = {128{1'b1}};                      pat_a[1] = {128{1'b1}};
    pat_s[2] = {16{8'h80}};                      pat_a[2] = {16{8'h7F}};
    pat_s[3] = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    pat_a[3] = 128'hDEAD_BEEF_CAFE_F00D_0F1E_2D3C_4B5A_6978;
    pat_s[4] = {$urandom(7), $urandom, $urandom, $urandom};
    pat_a[4] = {$urandom, $urandom, $urandom, $urandom};
    pat_s[5] = {$urandom, $urandom, $urandom, $urandom};
    pat_a[5] = {$urandom, $urandom, $urandom, $urandom};

    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", out_valid === 1'b0 && result === '0 &&
                 undef_flag === 1'b0 && other_class_flag === 1'b0,
          result, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: all-ones bytes shifted by 1 -> 0x7F each, no rounding
    run_vec({128{1'b1}}, '0, 4'b0001, 3'd7, 1'b1, 1'b0, "R7");
    // R8: 0xFF + (0xFF >> 1) wraps to 0x7E per byte
    run_vec({128{1'b1}}, {128{1'b1}}, 4'b0001, 3'd7, 1'b1, 1'b0, "R8");
    // R10: idle cycle holds result, out_valid low
    hold_v = result;
    @(negedge clk);
    check("R10", out_valid === 1'b0 && result === hold_v, result, hold_v);
    // R6: scalar ignores wide_sel, shift 64 leaves accumulator
    run_vec(pat_s[3], pat_a[3], 4'b1000, 3'd0, 1'b1, 1'b1, "R6");

    for (int p = 0; p < 6; p++)
      for (int imm = 0; imm < 128; imm++)
        for (int q = 0; q < 2; q++)
          for (int sc = 0; sc < 2; sc++)
            run_vec(pat_s[p], pat_a[p], 4'(imm >> 3), 3'(imm),
                    bit'(q), bit'(sc), "");
    finish_run();
  end
endmodule